// File: doc/BRIEF.md
# Word/Byte Adder with Status Flags

This unit performs the add step of a 16-bit microcontroller datapath. It sums a source operand and a destination operand, either over the full 16-bit word or over a single 8-bit byte. It registers four things: the sum, a write word ready for memory, the four arithmetic flags, and a status-register image that carries those flags at fixed bit positions.

The source operand is normally taken from the `src_in` input. A 3-bit code can instead choose a small built-in constant, so that common increments need no operand fetch. In byte mode the destination byte comes from one lane of `dst_in`, chosen by the address parity. The byte result is placed back into that same lane of the write word, and the other lane keeps its original value. The register-style result is the byte zero-extended to 16 bits.

The unit does no instruction decoding and no memory access. The surrounding datapath presents the operands together with `op_valid`, and the outputs change on the following clock edge.

Top module: `flag_adder16`

## Requirements
- R1: `stat_q` holds carry at bit 0, zero at bit 1, negative at bit 2 and overflow at bit 8. Every other bit of `stat_q` is 0. `flags_q` holds the same flags packed as {V,N,Z,C}, with C at bit 0.
- R2: In word mode, `sum_q` is the low 16 bits of source plus destination, and `wr_word_q` equals `sum_q`. C is set when the add carries out of bit 15.
- R3: V is set when both operands have the same sign bit in the active width and the result's sign bit differs from it. For example, 0x7FFF+0x0010 gives status 0x0104, and 0x8000+0xFF00 gives 0x7F00 with status 0x0101.
- R4: Z is set exactly when every bit of the active width of the result is 0. N equals the most significant bit of the active width.
- R5: In byte mode, C, V, N and Z are computed from the 8-bit sum of `src[7:0]` and the selected destination byte only. For example, 0x7F+0x10 gives 0x8F with V=1 and N=1, and 0x80+0xFF gives 0x7F with V=1 and C=1.
- R6: In byte mode, `sum_q[15:8]` is 0 and `sum_q[7:0]` is the byte sum.
- R7: In byte mode with `odd_lane`=0, the destination byte is `dst_in[7:0]`. `wr_word_q` carries the byte sum in bits 7:0 and keeps `dst_in[15:8]`.
- R8: In byte mode with `odd_lane`=1, the destination byte is `dst_in[15:8]`. `wr_word_q` carries the byte sum in bits 15:8 and keeps `dst_in[7:0]`. For example, 0xAA55 plus constant +1 gives 0xAB55.
- R9: `const_sel` replaces the source with a constant: 1 selects 0, 2 selects +1, 3 selects +2, 4 selects +4, 5 selects +8 and 6 selects 0xFFFF (-1).
- R10: `const_sel` values 0 and 7 use `src_in` as the source.
- R11: After reset, all outputs are 0. In a cycle with `op_valid` low, every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Capture an operation on this edge |
| src_in | input | 16 | External source operand |
| dst_in | input | 16 | Destination operand / memory word |
| byte_mode | input | 1 | 1 = 8-bit operation |
| odd_lane | input | 1 | Byte lane select (1 = high byte) |
| const_sel | input | 3 | Constant generator code |
| sum_q | output | 16 | Registered result (byte zero-extended) |
| wr_word_q | output | 16 | Registered lane-merged write word |
| flags_q | output | 4 | Registered flags {V,N,Z,C} |
| stat_q | output | 16 | Registered status-register image |

## Verification
The hardest situation to reach is a byte operation on the high lane whose flags differ from the flags the whole 16-bit word would produce. In that case the lane selection and the 8-bit flag logic must both be right at the same time. The bench sweeps every pair of low-lane byte operands exhaustively, with upper bytes chosen so that word-mode flags would disagree. It then strides through high-lane operand pairs with the opposite lane filled by a varying pattern. Each of the eight constant codes is also crossed with boundary destination values in both modes.

// File: rtl/flag_adder16.sv
module flag_adder16 #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [DW-1:0] src_in,
  input  logic [DW-1:0] dst_in,
  input  logic          byte_mode,
  input  logic          odd_lane,
  input  logic [2:0]    const_sel,
  output logic [DW-1:0] sum_q,
  output logic [DW-1:0] wr_word_q,
  output logic [3:0]    flags_q,
  output logic [DW-1:0] stat_q
);
  localparam int HW = DW / 2;

  logic [DW-1:0] k_val;
  logic          k_hit;

  always_comb begin
    k_hit = 1'b1;
    case (const_sel)
      3'd1:    k_val = '0;
      3'd2:    k_val = DW'(1);
      3'd3:    k_val = DW'(2);
      3'd4:    k_val = DW'(4);
      3'd5:    k_val = DW'(8);
      3'd6:    k_val = '1;
      default: begin k_val = '0; k_hit = 1'b0; end
    endcase
  end

  wire [DW-1:0] opa      = k_hit ? k_val : src_in;
  wire [HW-1:0] dst_byte = odd_lane ? dst_in[DW-1:HW] : dst_in[HW-1:0];

  wire [DW:0] wsum = {1'b0, opa} + {1'b0, dst_in};
  wire [HW:0] bsum = {1'b0, opa[HW-1:0]} + {1'b0, dst_byte};

  wire [DW-1:0] res  = byte_mode ? {{HW{1'b0}}, bsum[HW-1:0]} : wsum[DW-1:0];
  wire          c_nx = byte_mode ? bsum[HW] : wsum[DW];
  wire          a_s  = byte_mode ? opa[HW-1] : opa[DW-1];
  wire          b_s  = byte_mode ? dst_byte[HW-1] : dst_in[DW-1];
  wire          r_s  = byte_mode ? bsum[HW-1] : wsum[DW-1];
  wire          z_nx = (res == '0);
  wire          v_nx = (a_s == b_s) && (r_s != a_s);

  logic [DW-1:0] merged;
  always_comb begin
    if (!byte_mode)    merged = res;
    else if (odd_lane) merged = {bsum[HW-1:0], dst_in[HW-1:0]};
    else               merged = {dst_in[DW-1:HW], bsum[HW-1:0]};
  end

  logic [DW-1:0] stat_nx;
  always_comb begin
    stat_nx    = '0;
    stat_nx[0] = c_nx;
    stat_nx[1] = z_nx;
    stat_nx[2] = r_s;
    stat_nx[8] = v_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q     <= '0;
      wr_word_q <= '0;
      flags_q   <= '0;
      stat_q    <= '0;
    end else if (op_valid) begin
      sum_q     <= res;
      wr_word_q <= merged;
      flags_q   <= {v_nx, r_s, z_nx, c_nx};
      stat_q    <= stat_nx;
    end
  end
endmodule

// File: rtl/flag_adder16_chk.sv
module flag_adder16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [15:0] dst_in,
  input logic        byte_mode,
  input logic        odd_lane,
  input logic [15:0] sum_q,
  input logic [15:0] wr_word_q,
  input logic [3:0]  flags_q,
  input logic [15:0] stat_q
);
  AST_STAT_RSVD: assert property (@(posedge clk) disable iff (!rst_n) (stat_q & 16'hFEF8) == 16'h0000); // R1
  AST_STAT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) {stat_q[8], stat_q[2], stat_q[1], stat_q[0]} == flags_q); // R1
  AST_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n) op_valid && !byte_mode |=> wr_word_q == sum_q); // R2
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) op_valid |=> stat_q[1] == (sum_q == 16'h0000)); // R4
  AST_WORD_NEG: assert property (@(posedge clk) disable iff (!rst_n) op_valid && !byte_mode |=> stat_q[2] == sum_q[15]); // R4
  AST_BYTE_NEG: assert property (@(posedge clk) disable iff (!rst_n) op_valid && byte_mode |=> stat_q[2] == sum_q[7]); // R5
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n) op_valid && byte_mode |=> sum_q[15:8] == 8'h00); // R6
  AST_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n) op_valid && byte_mode && !odd_lane |=> wr_word_q[15:8] == $past(dst_in[15:8]) && wr_word_q[7:0] == sum_q[7:0]); // R7
  AST_HIGH_LANE: assert property (@(posedge clk) disable iff (!rst_n) op_valid && byte_mode && odd_lane |=> wr_word_q[7:0] == $past(dst_in[7:0]) && wr_word_q[15:8] == sum_q[7:0]); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !op_valid |=> $stable(sum_q) && $stable(wr_word_q) && $stable(stat_q)); // R11
endmodule

bind flag_adder16 flag_adder16_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .dst_in(dst_in),
  .byte_mode(byte_mode), .odd_lane(odd_lane), .sum_q(sum_q),
  .wr_word_q(wr_word_q), .flags_q(flags_q), .stat_q(stat_q)
);

// File: tb/flag_adder16_tb_top.sv
module flag_adder16_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0;
  logic byte_mode = 1'b0, odd_lane = 1'b0;
  logic [2:0] const_sel = 3'd0;
  logic [15:0] sum_q, wr_word_q, stat_q;
  logic [3:0] flags_q;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flag_adder16 dut_i (.*);

  function automatic logic [15:0] kval(input logic [2:0] c, input logic [15:0] s);
    case (c)
      3'd1: return 16'h0000;
      3'd2: return 16'h0001;
      3'd3: return 16'h0002;
      3'd4: return 16'h0004;
      3'd5: return 16'h0008;
      3'd6: return 16'hFFFF;
      default: return s;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [15:0] s, input logic [15:0] d,
                     input logic bm, input logic odd, input logic [2:0] cs);
    int a, b, sum, w, bits;
    logic [15:0] e_sum, e_wr, e_st;
    logic c, z, n, v, as, bs, rs;
    @(negedge clk);
    src_in = s; dst_in = d; byte_mode = bm; odd_lane = odd; const_sel = cs; op_valid = 1'b1;
    a = int'(kval(cs, s));
    if (bm) begin
      bits = 8;
      a = a % 256;
      b = odd ? int'(d[15:8]) : int'(d[7:0]);
    end else begin
      bits = 16;
      b = int'(d);
    end
    sum = a + b;
    w = sum % (1 << bits);
    c = (sum >= (1 << bits));
    z = (w == 0);
    as = ((a >> (bits-1)) & 1) != 0;
    bs = ((b >> (bits-1)) & 1) != 0;
    rs = ((w >> (bits-1)) & 1) != 0;
    n = rs;
    v = (as == bs) && (rs != as);
    e_sum = 16'(w);
    if (!bm) e_wr = 16'(w);
    else if (odd) e_wr = {8'(w), d[7:0]};
    else e_wr = {d[15:8], 8'(w)};
    e_st = {7'b0, v, 5'b0, n, z, c};
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " sum"}, sum_q, e_sum);
    chk({tag, " wr"}, wr_word_q, e_wr);
    chk({tag, " R1 status"}, stat_q, e_st);
    chk({tag, " R1 flags"}, {12'b0, flags_q}, {12'b0, v, n, z, c});
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset sum", sum_q, 16'h0);
    chk("R11 reset wr", wr_word_q, 16'h0);
    chk("R11 reset stat", stat_q, 16'h0);
    rst_n = 1'b1;

    run("R3 V N word", 16'h7FFF, 16'h0010, 0, 0, 0);
    chk("R3 status 0104", stat_q, 16'h0104);
    run("R3 V C word", 16'h8000, 16'hFF00, 0, 0, 0);
    chk("R3 status 0101", stat_q, 16'h0101);
    run("R5 byte 8F", 16'h007F, 16'h0010, 1, 0, 0);
    chk("R5 status 0104", stat_q, 16'h0104);
    run("R5 byte 7F", 16'h0080, 16'h00FF, 1, 0, 0);
    chk("R5 status 0101", stat_q, 16'h0101);
    run("R4 zero word", 16'h0001, 16'hFFFF, 0, 0, 0);
    chk("R4 status 0003", stat_q, 16'h0003);
    run("R8 high lane +1", 16'h0000, 16'hAA55, 1, 1, 3'd2);
    chk("R8 AB55", wr_word_q, 16'hAB55);
    run("R7 low lane +1", 16'h0000, 16'hAA55, 1, 0, 3'd2);
    chk("R7 AA56", wr_word_q, 16'hAA56);

    // R11: op_valid low with changed inputs
    @(negedge clk);
    src_in = 16'h1234; dst_in = 16'h4321; byte_mode = 0; const_sel = 0;
    @(negedge clk);
    chk("R11 hold wr", wr_word_q, 16'hAA56);
    chk("R11 hold stat", stat_q, 16'h0000);

    // R9 R10: every code, both modes, boundary destinations
    for (int cs = 0; cs < 8; cs++)
      for (int di = 0; di < 6; di++) begin
        logic [15:0] dv;
        case (di)
          0: dv = 16'h0000; 1: dv = 16'hFFFF; 2: dv = 16'h7FFF;
          3: dv = 16'h80F8; 4: dv = 16'h4444; default: dv = 16'hAA7F;
        endcase
        run("R9 R10 word const", 16'h3C5A, dv, 0, 0, 3'(cs));
        run("R9 R10 byte lo const", 16'h3C5A, dv, 1, 0, 3'(cs));
        run("R9 R10 byte hi const", 16'h3C5A, dv, 1, 1, 3'(cs));
      end

    // R2 R3 R4: word sweep over edge-rich values
    for (int i = 0; i < 48; i++)
      for (int j = 0; j < 48; j++) begin
        logic [15:0] x, y;
        x = 16'((i * 16'h0557) ^ ((i & 3) == 0 ? 16'h8000 : 16'h0000));
        y = 16'((j * 16'h1553) ^ ((j & 1) ? 16'h7FFF : 16'h0000));
        run("R2 R3 R4 word", x, y, 0, 0, 3'd0);
      end

    // R5 R6 R7: exhaustive low lane
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run("R5 R6 R7 byte lo", {8'(b ^ 8'hC3), 8'(a)}, {8'(a ^ 8'h81), 8'(b)}, 1, 0, 3'd7);

    // R5 R6 R8: strided high lane
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5)
        run("R5 R6 R8 byte hi", {8'(b), 8'(a)}, {8'(b), 8'(a + b)}, 1, 1, 3'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule